// File: doc/BRIEF.md
# Packet Header Address Filter

This block sits in a byte-stream receive path just after the point where the sync word has been found. It takes in up to four header bytes and stores them. It tests each stored byte against a programmed check value. Only the bits picked by a mask take part in the test. A per-byte enable picks which positions are tested at all, and a per-byte broadcast option also lets an all-ones byte through. When every tested byte passes, the block takes the payload length, either from the byte after the header or from a programmed register. It then forwards that many payload bytes to the FIFO writer and ends with a one-cycle accept pulse.

When a tested byte fails, the block raises a header error flag and pulses a drop signal. It then ignores the rest of the packet until the next sync event. Whatever the outcome, the captured header bytes and the length stay readable until the next packet starts.

Top module: `hdr_filter`

## Requirements
- R1: After reset, `rxHeader`, `rxLength`, `outByte` and `hdrError` are zero, and `outValid`, `pktAccept` and `pktDrop` are low.
- R2: `syncHit` starts a new packet on that clock edge. Any packet in progress is abandoned. `rxHeader` is cleared to zero and `hdrError` is cleared. `rxLength` is loaded with `cfgPktLen` when `cfgFixedLen` is 1, and with zero otherwise.
- R3: The header holds N = min(`cfgHdrLen`, 4) bytes. Values 5 to 7 act as 4. The first byte accepted after `syncHit` goes to index N-1, and each later byte goes to the next lower index. Byte i is stored in `rxHeader[8i+7:8i]` whether the check passes or fails. Indices at or above N read zero.
- R4: Header byte i fails only when `cfgByteEn[i]` is 1 and some bit b with `cfgMask[8i+b]` equal to 1 differs from `cfgCheck[8i+b]`. Bits whose mask is 0, and bytes whose enable is 0, never fail.
- R5: When both `cfgBcastEn[i]` and `cfgByteEn[i]` are 1, header byte i equal to FFh passes, whatever the check and mask values.
- R6: If any header byte of a packet fails, then on the edge that takes the last header byte `hdrError` is set and `pktDrop` pulses high for one cycle. `hdrError` stays set until the next `syncHit`. No payload byte of that packet is forwarded and `pktAccept` does not pulse for it.
- R7: With `cfgFixedLen` at 0, the byte after the header is stored in `rxLength` and gives the number of payload bytes.
- R8: With `cfgFixedLen` at 1, no length byte is taken and `cfgPktLen` payload bytes follow the header directly.
- R9: Each payload byte taken with `inValid` appears on `outByte` with `outValid` high for one cycle, one clock after it is sampled, in arrival order. `pktAccept` pulses in the same cycle as the last payload byte.
- R10: A payload length of zero ends the packet at once. `pktAccept` pulses one clock after the edge that took the length byte. In fixed mode it pulses after the last header byte, or after `syncHit` itself when N is 0.
- R11: While no packet is in progress, bytes offered with `inValid` are ignored: `outValid`, `pktAccept` and `pktDrop` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| syncHit | input | 1 | Sync word found; starts a packet |
| inValid | input | 1 | `inByte` carries a received byte this cycle |
| inByte | input | 8 | Received byte |
| cfgHdrLen | input | 3 | Number of header bytes (0 to 4; larger values act as 4) |
| cfgCheck | input | 32 | Check value, byte i in bits 8i+7:8i |
| cfgMask | input | 32 | Per-bit compare mask |
| cfgByteEn | input | 4 | Per-byte check enable |
| cfgBcastEn | input | 4 | Per-byte broadcast (FFh) accept enable |
| cfgFixedLen | input | 1 | 1: length from `cfgPktLen`; 0: length byte follows the header |
| cfgPktLen | input | 8 | Programmed payload length |
| rxHeader | output | 32 | Captured header bytes |
| rxLength | output | 8 | Payload length of the current or last packet |
| hdrError | output | 1 | Header check failed for the current packet |
| outValid | output | 1 | Payload byte valid towards the FIFO writer |
| outByte | output | 8 | Payload byte |
| pktAccept | output | 1 | One-cycle pulse: packet complete and accepted |
| pktDrop | output | 1 | One-cycle pulse: packet rejected |

## Verification
The filter is tried with headers that match exactly, and with headers whose only differing bit is masked off. It is also tried with a differing bit in a masked position of the first byte and of a middle byte, with that byte's enable switched off, and with an FFh byte whose broadcast enable is set at the right or the wrong position. Together these separate the mask, the enable, the broadcast path and error memory across bytes. Header lengths of 0, 1, 2, 3, 4 and 7 show the descending byte placement and the clamp. Variable and fixed length modes, including zero lengths, show where the payload count comes from and when the accept pulse fires. Bytes sent after a drop and while idle show that discarded traffic never reaches the FIFO writer.

// File: rtl/hdr_filter_pkg.sv
package hdr_filter_pkg;
  localparam int BYTE_W  = 8;
  localparam int NUM_HDR = 4;
  localparam int IDX_W   = $clog2(NUM_HDR);
  localparam int HDR_W   = BYTE_W * NUM_HDR;

  // strobes from control to datapath, one set per clock
  typedef struct packed {
    logic             start;   // new packet: clear captured state
    logic             capHdr;  // store header byte at hdrIdx
    logic [IDX_W-1:0] hdrIdx;  // position of the byte on inByte
    logic             capLen;  // store in-band length byte
    logic             fwd;     // forward payload byte
    logic             setErr;  // header check failed
  } strobeT;
endpackage

// File: rtl/hdr_filter_ctrl.sv
module hdr_filter_ctrl
  import hdr_filter_pkg::*;
#(
  parameter int HL_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              syncHit,
  input  logic              inValid,
  input  logic [BYTE_W-1:0] inByte,
  input  logic [HL_W-1:0]   cfgHdrLen,
  input  logic              cfgFixedLen,
  input  logic [BYTE_W-1:0] cfgPktLen,
  input  logic              hdrFail,
  output strobeT            strb,
  output logic              pktAccept,
  output logic              pktDrop
);
  typedef enum logic [1:0] {S_IDLE, S_HDR, S_LEN, S_DATA} stateT;

  stateT             state, stateNxt;
  logic [IDX_W-1:0]  idx, idxNxt;
  logic [BYTE_W-1:0] remain, remainNxt;
  logic              acceptNxt, dropNxt, goPost;
  logic [IDX_W:0]    hdrCount;

  // header length clamped to the number of header positions
  always_comb begin
    if (cfgHdrLen > HL_W'(NUM_HDR)) hdrCount = (IDX_W+1)'(NUM_HDR);
    else                            hdrCount = (IDX_W+1)'(cfgHdrLen);
  end

  always_comb begin
    stateNxt    = state;
    idxNxt      = idx;
    remainNxt   = remain;
    acceptNxt   = 1'b0;
    dropNxt     = 1'b0;
    goPost      = 1'b0;
    strb        = '0;
    strb.hdrIdx = idx;
    if (syncHit) begin
      strb.start = 1'b1;
      if (hdrCount != '0) begin
        stateNxt = S_HDR;
        idxNxt   = IDX_W'(hdrCount - 1'b1);
      end else begin
        goPost = 1'b1;
      end
    end else if (inValid) begin
      case (state)
        S_HDR: begin
          strb.capHdr = 1'b1;
          if (idx == '0) begin
            if (hdrFail) begin
              strb.setErr = 1'b1;
              dropNxt     = 1'b1;
              stateNxt    = S_IDLE;
            end else begin
              goPost = 1'b1;
            end
          end else begin
            idxNxt = idx - 1'b1;
          end
        end
        S_LEN: begin
          strb.capLen = 1'b1;
          if (inByte == '0) begin
            acceptNxt = 1'b1;
            stateNxt  = S_IDLE;
          end else begin
            remainNxt = inByte;
            stateNxt  = S_DATA;
          end
        end
        S_DATA: begin
          strb.fwd = 1'b1;
          if (remain == BYTE_W'(1)) begin
            acceptNxt = 1'b1;
            stateNxt  = S_IDLE;
          end else begin
            remainNxt = remain - 1'b1;
          end
        end
        default: ;
      endcase
    end
    // header done (or absent): pick the payload length source
    if (goPost) begin
      if (!cfgFixedLen) begin
        stateNxt = S_LEN;
      end else if (cfgPktLen == '0) begin
        acceptNxt = 1'b1;
        stateNxt  = S_IDLE;
      end else begin
        remainNxt = cfgPktLen;
        stateNxt  = S_DATA;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      idx       <= '0;
      remain    <= '0;
      pktAccept <= 1'b0;
      pktDrop   <= 1'b0;
    end else begin
      state     <= stateNxt;
      idx       <= idxNxt;
      remain    <= remainNxt;
      pktAccept <= acceptNxt;
      pktDrop   <= dropNxt;
    end
  end

  // R6: a packet ends in at most one way
  assert_one_end_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({pktAccept, pktDrop}));

  // R6: a drop only follows a header byte
  assert_drop_after_hdr_R6: assert property (@(posedge clk) disable iff (!rstN)
    pktDrop |-> ($past(state) == S_HDR));

  // R11: nothing ends while idle without a new sync
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && !syncHit) |=> (!pktAccept && !pktDrop));

  // R9: payload continues until the count runs out
  assert_data_runs_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DATA && inValid && !syncHit && remain != BYTE_W'(1))
      |=> (state == S_DATA && !pktAccept));
endmodule

// File: rtl/hdr_filter_dp.sv
module hdr_filter_dp
  import hdr_filter_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             strb,
  input  logic [BYTE_W-1:0]  inByte,
  input  logic [HDR_W-1:0]   cfgCheck,
  input  logic [HDR_W-1:0]   cfgMask,
  input  logic [NUM_HDR-1:0] cfgByteEn,
  input  logic [NUM_HDR-1:0] cfgBcastEn,
  input  logic               cfgFixedLen,
  input  logic [BYTE_W-1:0]  cfgPktLen,
  output logic               hdrFail,
  output logic [HDR_W-1:0]   rxHeader,
  output logic [BYTE_W-1:0]  rxLength,
  output logic               hdrError,
  output logic               outValid,
  output logic [BYTE_W-1:0]  outByte
);
  logic [NUM_HDR-1:0] byteMiss;
  logic               curMiss, missAcc;

  // per-position masked compare with broadcast escape
  for (genvar gi = 0; gi < NUM_HDR; gi++) begin : g_cmp
    logic diffBits, isBcast;
    assign diffBits = |((inByte ^ cfgCheck[gi*BYTE_W +: BYTE_W]) & cfgMask[gi*BYTE_W +: BYTE_W]);
    assign isBcast  = cfgBcastEn[gi] && (&inByte);
    assign byteMiss[gi] = cfgByteEn[gi] && diffBits && !isBcast;
  end

  assign curMiss = byteMiss[strb.hdrIdx];
  assign hdrFail = missAcc | curMiss;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxHeader <= '0;
      rxLength <= '0;
      hdrError <= 1'b0;
      missAcc  <= 1'b0;
      outValid <= 1'b0;
      outByte  <= '0;
    end else begin
      if (strb.start) begin
        rxHeader <= '0;
        missAcc  <= 1'b0;
        hdrError <= 1'b0;
        rxLength <= cfgFixedLen ? cfgPktLen : '0;
      end
      if (strb.capHdr) begin
        rxHeader[strb.hdrIdx*BYTE_W +: BYTE_W] <= inByte;
        missAcc <= missAcc | curMiss;
      end
      if (strb.setErr) hdrError <= 1'b1;
      if (strb.capLen) rxLength <= inByte;
      outValid <= strb.fwd;
      if (strb.fwd) outByte <= inByte;
    end
  end

  // R2: a new packet starts from a clean header and error
  assert_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.start |=> (rxHeader == '0 && !hdrError));

  // R6: the error flag holds until the next packet
  assert_err_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (hdrError && !strb.start) |=> hdrError);

  // R3: the header only changes on a capture or a start
  assert_hdr_keep_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.start && !strb.capHdr) |=> $stable(rxHeader));

  // R7: the length only changes on a capture or a start
  assert_len_keep_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.start && !strb.capLen) |=> $stable(rxLength));
endmodule

// File: rtl/hdr_filter.sv
module hdr_filter
  import hdr_filter_pkg::*;
#(
  parameter int HL_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               syncHit,
  input  logic               inValid,
  input  logic [BYTE_W-1:0]  inByte,
  input  logic [HL_W-1:0]    cfgHdrLen,
  input  logic [HDR_W-1:0]   cfgCheck,
  input  logic [HDR_W-1:0]   cfgMask,
  input  logic [NUM_HDR-1:0] cfgByteEn,
  input  logic [NUM_HDR-1:0] cfgBcastEn,
  input  logic               cfgFixedLen,
  input  logic [BYTE_W-1:0]  cfgPktLen,
  output logic [HDR_W-1:0]   rxHeader,
  output logic [BYTE_W-1:0]  rxLength,
  output logic               hdrError,
  output logic               outValid,
  output logic [BYTE_W-1:0]  outByte,
  output logic               pktAccept,
  output logic               pktDrop
);
  strobeT strb;
  logic   hdrFail;

  hdr_filter_ctrl #(.HL_W(HL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .syncHit(syncHit), .inValid(inValid),
    .inByte(inByte), .cfgHdrLen(cfgHdrLen), .cfgFixedLen(cfgFixedLen),
    .cfgPktLen(cfgPktLen), .hdrFail(hdrFail), .strb(strb),
    .pktAccept(pktAccept), .pktDrop(pktDrop)
  );

  hdr_filter_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .inByte(inByte),
    .cfgCheck(cfgCheck), .cfgMask(cfgMask), .cfgByteEn(cfgByteEn),
    .cfgBcastEn(cfgBcastEn), .cfgFixedLen(cfgFixedLen), .cfgPktLen(cfgPktLen),
    .hdrFail(hdrFail), .rxHeader(rxHeader), .rxLength(rxLength),
    .hdrError(hdrError), .outValid(outValid), .outByte(outByte)
  );

  // R6: a drop always comes with the error flag
  assert_drop_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    pktDrop |-> hdrError);
endmodule

// File: tb/hdr_filter_test.sv
module hdr_filter_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic        syncHit, inValid;
  logic [7:0]  inByte;
  logic [2:0]  cfgHdrLen;
  logic [31:0] cfgCheck, cfgMask;
  logic [3:0]  cfgByteEn, cfgBcastEn;
  logic        cfgFixedLen;
  logic [7:0]  cfgPktLen;
  logic [31:0] rxHeader;
  logic [7:0]  rxLength, outByte;
  logic        hdrError, outValid, pktAccept, pktDrop;

  always #5 clk = ~clk;

  hdr_filter uut (
    .clk(clk), .rstN(rstN), .syncHit(syncHit), .inValid(inValid), .inByte(inByte),
    .cfgHdrLen(cfgHdrLen), .cfgCheck(cfgCheck), .cfgMask(cfgMask),
    .cfgByteEn(cfgByteEn), .cfgBcastEn(cfgBcastEn), .cfgFixedLen(cfgFixedLen),
    .cfgPktLen(cfgPktLen), .rxHeader(rxHeader), .rxLength(rxLength),
    .hdrError(hdrError), .outValid(outValid), .outByte(outByte),
    .pktAccept(pktAccept), .pktDrop(pktDrop)
  );

  int compared = 0, mismatched = 0, gapCnt = 0;
  bit running = 0;

  // scoreboard queues
  logic [7:0]  dataQ[$];
  bit          accQ[$];
  logic [31:0] hdrQ[$];
  logic [7:0]  lenQ[$];
  string       tagQ[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit byteOk(input int i, input logic [7:0] b);
    if (!cfgByteEn[i]) return 1'b1;
    if (cfgBcastEn[i] && b == 8'hFF) return 1'b1;
    return ((b ^ cfgCheck[i*8 +: 8]) & cfgMask[i*8 +: 8]) == 8'h00;
  endfunction

  task automatic driveByte(input logic [7:0] b);
    inByte  = b;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    gapCnt++;
    if (gapCnt % 3 == 0) @(negedge clk);
  endtask

  // driver: pushes expected results, then drives the packet
  task automatic sendPacket(input int hl, input logic [31:0] hv, input int plen,
                            input string tag);
    int n;
    logic [31:0] eh;
    bit ok;
    n  = (hl > 4) ? 4 : hl;
    eh = '0;
    ok = 1'b1;
    for (int i = 0; i < n; i++) begin
      eh[i*8 +: 8] = hv[i*8 +: 8];
      if (!byteOk(i, hv[i*8 +: 8])) ok = 1'b0;
    end
    cfgHdrLen = 3'(hl);
    accQ.push_back(ok);
    hdrQ.push_back(eh);
    lenQ.push_back(cfgFixedLen ? cfgPktLen : (ok ? 8'(plen) : 8'h00));
    tagQ.push_back(tag);
    if (ok) for (int k = 0; k < plen; k++) dataQ.push_back(8'(plen * 17 + k * 3 + 1));
    syncHit = 1'b1;
    @(negedge clk);
    syncHit = 1'b0;
    for (int i = n - 1; i >= 0; i--) driveByte(hv[i*8 +: 8]);
    if (!cfgFixedLen) driveByte(8'(plen));
    for (int k = 0; k < plen; k++) driveByte(8'(plen * 17 + k * 3 + 1));
    repeat (3) @(negedge clk);
  endtask

  // R11: offered bytes while idle must not reach the outputs
  task automatic idleBytes();
    for (int k = 0; k < 3; k++) begin
      inByte  = 8'(8'hC0 + k);
      inValid = 1'b1;
      @(negedge clk);
      check(!outValid && !pktAccept && !pktDrop, "R11", "idle byte leaked",
            {29'd0, outValid, pktAccept, pktDrop}, 32'd0);
    end
    inValid = 1'b0;
    @(negedge clk);
  endtask

  // monitor: compares design output against the queues
  always @(negedge clk) begin
    if (running) begin
      if (outValid) begin
        if (dataQ.size() == 0) check(1'b0, "R9", "unexpected payload byte", {24'd0, outByte}, 32'd0);
        else begin
          logic [7:0] e;
          e = dataQ.pop_front();
          check(outByte == e, "R9", "payload byte", {24'd0, outByte}, {24'd0, e});
        end
      end
      if (pktAccept || pktDrop) begin
        if (accQ.size() == 0) check(1'b0, "R6", "unexpected packet end", {30'd0, pktAccept, pktDrop}, 32'd0);
        else begin
          bit ea;
          logic [31:0] eh;
          logic [7:0] el;
          string t;
          ea = accQ.pop_front();
          eh = hdrQ.pop_front();
          el = lenQ.pop_front();
          t  = tagQ.pop_front();
          check(pktAccept == ea && pktDrop == !ea, t, "outcome (accept)", {31'd0, pktAccept}, {31'd0, ea});
          check(rxHeader == eh, t, "rxHeader", rxHeader, eh);
          check(rxLength == el, t, "rxLength", {24'd0, rxLength}, {24'd0, el});
          check(hdrError == !ea, t, "hdrError", {31'd0, hdrError}, {31'd0, !ea});
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rstN = 1'b0; syncHit = 1'b0; inValid = 1'b0; inByte = '0;
    cfgHdrLen = 3'd4; cfgCheck = 32'hA5C3_1E77; cfgMask = 32'hFFFF_FFFF;
    cfgByteEn = 4'hF; cfgBcastEn = 4'h0; cfgFixedLen = 1'b0; cfgPktLen = 8'd0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(rxHeader == 0 && rxLength == 0 && outByte == 0 && !hdrError &&
          !outValid && !pktAccept && !pktDrop, "R1", "reset outputs",
          {rxLength, outByte, 16'd0} | rxHeader, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    running = 1'b1;

    idleBytes();                                           // R11 before any packet
    sendPacket(4, 32'hA5C3_1E77, 3, "R3 R7 R9 exact");     // full match
    cfgMask = 32'hFFFF_FF7F;
    sendPacket(4, 32'hA5C3_1EF7, 2, "R4 masked bit");      // differs only where mask is 0
    cfgMask = 32'hFFFF_FFFF;
    sendPacket(4, 32'hA5D3_1E77, 4, "R4 R6 middle byte");  // byte 2 fails, payload dropped
    idleBytes();                                           // R11 after a drop

    // R2: a sync clears header and error, loads length
    cfgFixedLen = 1'b1; cfgPktLen = 8'd9;
    syncHit = 1'b1;
    @(negedge clk);
    syncHit = 1'b0;
    check(rxHeader == 0, "R2", "header cleared", rxHeader, 32'd0);
    check(!hdrError, "R2", "error cleared", {31'd0, hdrError}, 32'd0);
    check(rxLength == 8'd9, "R2", "length loaded", {24'd0, rxLength}, 32'd9);
    cfgFixedLen = 1'b0;

    sendPacket(4, 32'hB5C3_1E77, 2, "R6 first byte");      // early failure remembered
    cfgByteEn = 4'hB;
    sendPacket(4, 32'hA5D3_1E77, 2, "R4 byte disabled");
    cfgByteEn = 4'hF; cfgBcastEn = 4'h2;
    sendPacket(4, 32'hA5C3_FF77, 3, "R5 broadcast");
    cfgBcastEn = 4'h4;
    sendPacket(4, 32'hA5C3_FF77, 3, "R5 wrong position");
    cfgBcastEn = 4'h0;
    sendPacket(2, 32'h1234_1E77, 2, "R3 two bytes");
    sendPacket(7, 32'hA5C3_1E77, 2, "R3 clamp");
    sendPacket(0, 32'h0, 0, "R10 variable zero");
    sendPacket(0, 32'h0, 5, "R7 no header");
    cfgFixedLen = 1'b1; cfgPktLen = 8'd5;
    sendPacket(3, 32'h00C3_1E77, 5, "R8 fixed");
    cfgPktLen = 8'd0;
    sendPacket(1, 32'h0000_0077, 0, "R10 fixed zero");
    sendPacket(0, 32'h0, 0, "R10 fixed zero no header");
    cfgPktLen = 8'd3;
    sendPacket(2, 32'h0000_1F77, 3, "R6 R8 fixed drop");
    cfgFixedLen = 1'b0;

    repeat (5) @(negedge clk);
    check(dataQ.size() == 0, "R9", "payload bytes missing", dataQ.size(), 32'd0);
    check(accQ.size() == 0, "R6", "packet ends missing", accQ.size(), 32'd0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule